// File: doc/BRIEF.md
# Rectifier Sector Gate Pattern Generator

This block drives the six gates of a current-source rectifier stage built from bidirectional switches: one upper and one lower switch for each of the three input phases. A controller supplies the input-current sector (1 to 6), a compare value for the first active current vector, the PWM period and a free-running time base count. In every sector one switch conducts for the whole period and three stay off. The remaining two switches split the period at the compare point, so exactly two switches conduct at any moment. No zero vector is ever applied, and the dc link always sees one of two line-to-line voltages.

Sector, compare value and period are captured only in the cycle where the time base count is zero. A pattern therefore never changes partway through a period. The compare value is saturated at the period. Sector codes 0 and 7 are rejected: all gates turn off and an error flag is raised. Each phase has its own registered output leg, with an upper and a lower gate output, generated from a common decoded pattern.

Top module: `rect_gate_gen`

## Requirements
- R1: After reset all six gates are off and `sector_err_o` is low. They stay in that state until the first cycle in which `tb_cnt_i` is zero.
- R2: `sector_i`, `duty_i` and `period_i` are sampled only in a cycle where `tb_cnt_i` is zero. Changes to them at any other count have no effect on the outputs until the next zero count.
- R3: Outputs are registered. The gate and error values that belong to the count presented in one cycle appear after the next rising clock edge.
- R4: Bit 0, bit 1 and bit 2 of `gate_up_o` and of `gate_lo_o` belong to phases a, b and c. For each sector the clamped switch, the first modulated switch and the second modulated switch are:
  - sector 1: a-upper, b-lower, c-lower
  - sector 2: c-lower, a-upper, b-upper
  - sector 3: b-upper, a-lower, c-lower
  - sector 4: a-lower, b-upper, c-upper
  - sector 5: c-upper, b-lower, a-lower
  - sector 6: b-lower, a-upper, c-upper

  The other three switches are off.
- R5: Let `cmp` be the captured compare value. The first modulated switch is on while the count is greater than or equal to `cmp`. The second is on while the count is less than `cmp`.
- R6: In a valid sector exactly two gates are on. The upper and lower gate of one phase are never on together.
- R7: A captured sector of 0 or 7 turns all gates off and sets `sector_err_o` high. A captured valid sector clears `sector_err_o`.
- R8: A `duty_i` above `period_i` is treated as equal to `period_i`. The second modulated switch is then on for counts below the period, and the first is on only at the count equal to the period.
- R9: A `duty_i` of zero keeps the first modulated switch on for the whole period and the second switch off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sector_i | input | 3 | Input-current sector, valid codes 1 to 6 |
| duty_i | input | CNT_W | Compare point of the first active vector, in counts |
| period_i | input | CNT_W | PWM period in counts |
| tb_cnt_i | input | CNT_W | Free-running time base count; zero marks a new period |
| gate_up_o | output | 3 | Upper switch gates, bit 0 = phase a |
| gate_lo_o | output | 3 | Lower switch gates, bit 0 = phase a |
| sector_err_o | output | 1 | Captured sector code was 0 or 7 |

## Verification
Every result of this block is due exactly one rising edge after the count that produced it is presented. This covers the pattern captured at a zero count as well: that pattern governs the very output registered at that same edge. The bench drives the inputs on the falling edge and pushes the expected gate and error values into a queue. The monitor pops one item per rising edge and compares it a short delay after the edge. A missing or extra pipeline stage therefore shows up as a mismatch against the neighbouring count.

// File: rtl/rgg_pkg.sv
package rgg_pkg;

  localparam int NLEG = 3;
  localparam int NSW  = 2 * NLEG;

  // switch index: 0..2 = upper a,b,c ; 3..5 = lower a,b,c
  typedef struct packed {
    logic             valid;
    logic [NSW-1:0]   clamp;
    logic [NSW-1:0]   first;
    logic [NSW-1:0]   second;
  } rgg_pat_t;

  function automatic logic [NSW-1:0] rgg_bit(input int idx);
    logic [NSW-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  function automatic rgg_pat_t rgg_decode(input logic [2:0] sec);
    rgg_pat_t p;
    p = '0;
    p.valid = 1'b1;
    unique case (sec)
      3'd1: begin p.clamp = rgg_bit(0); p.first = rgg_bit(4); p.second = rgg_bit(5); end
      3'd2: begin p.clamp = rgg_bit(5); p.first = rgg_bit(0); p.second = rgg_bit(1); end
      3'd3: begin p.clamp = rgg_bit(1); p.first = rgg_bit(3); p.second = rgg_bit(5); end
      3'd4: begin p.clamp = rgg_bit(3); p.first = rgg_bit(1); p.second = rgg_bit(2); end
      3'd5: begin p.clamp = rgg_bit(2); p.first = rgg_bit(4); p.second = rgg_bit(3); end
      3'd6: begin p.clamp = rgg_bit(4); p.first = rgg_bit(0); p.second = rgg_bit(2); end
      default: p.valid = 1'b0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/rgg_shadow.sv
module rgg_shadow #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       sector_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             wrap_o,
  output logic             armed_o,
  output logic [2:0]       sector_o,
  output logic [CNT_W-1:0] cmp_o
);

  function automatic logic [CNT_W-1:0] sat_cmp(input logic [CNT_W-1:0] d,
                                               input logic [CNT_W-1:0] p);
    return (d > p) ? p : d;
  endfunction

  logic             armed_q;
  logic [2:0]       sector_q;
  logic [CNT_W-1:0] cmp_q;

  assign wrap_o   = (cnt_i == '0);
  // the pattern taken at a zero count already governs that count
  assign armed_o  = wrap_o ? 1'b1 : armed_q;
  assign sector_o = wrap_o ? sector_i : sector_q;
  assign cmp_o    = wrap_o ? sat_cmp(duty_i, period_i) : cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      sector_q <= '0;
      cmp_q    <= '0;
    end else if (wrap_o) begin
      armed_q  <= 1'b1;
      sector_q <= sector_i;
      cmp_q    <= sat_cmp(duty_i, period_i);
    end
  end

endmodule

// File: rtl/rgg_window.sv
module rgg_window #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             first_win_o,
  output logic             second_win_o
);

  assign first_win_o  = (cnt_i >= cmp_i);
  assign second_win_o = (cnt_i <  cmp_i);

endmodule

// File: rtl/rgg_leg.sv
module rgg_leg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable_i,
  input  logic [1:0] clamp_i,   // {lower, upper}
  input  logic [1:0] first_i,
  input  logic [1:0] second_i,
  input  logic       first_win_i,
  input  logic       second_win_i,
  output logic       up_o,
  output logic       lo_o
);

  logic [1:0] drive_d;
  logic [1:0] drive_q;

  always_comb begin
    drive_d = clamp_i
            | (first_i  & {2{first_win_i}})
            | (second_i & {2{second_win_i}});
    if (!enable_i) drive_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive_q <= '0;
    else        drive_q <= drive_d;
  end

  assign up_o = drive_q[0];
  assign lo_o = drive_q[1];

endmodule

// File: rtl/rect_gate_gen.sv
module rect_gate_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       sector_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] tb_cnt_i,
  output logic [2:0]       gate_up_o,
  output logic [2:0]       gate_lo_o,
  output logic             sector_err_o
);
  import rgg_pkg::*;

  logic             wrap;
  logic             armed;
  logic [2:0]       eff_sector;
  logic [CNT_W-1:0] eff_cmp;
  logic             first_win;
  logic             second_win;
  rgg_pat_t         pat;
  logic             leg_en;
  logic             err_q;

  rgg_shadow #(.CNT_W(CNT_W)) shadow_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sector_i (sector_i),
    .duty_i   (duty_i),
    .period_i (period_i),
    .cnt_i    (tb_cnt_i),
    .wrap_o   (wrap),
    .armed_o  (armed),
    .sector_o (eff_sector),
    .cmp_o    (eff_cmp)
  );

  rgg_window #(.CNT_W(CNT_W)) window_i (
    .cnt_i        (tb_cnt_i),
    .cmp_i        (eff_cmp),
    .first_win_o  (first_win),
    .second_win_o (second_win)
  );

  assign pat    = rgg_decode(eff_sector);
  assign leg_en = armed & pat.valid;

  for (genvar ph = 0; ph < NLEG; ph++) begin : g_leg
    rgg_leg leg_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable_i     (leg_en),
      .clamp_i      ({pat.clamp[ph+NLEG],  pat.clamp[ph]}),
      .first_i      ({pat.first[ph+NLEG],  pat.first[ph]}),
      .second_i     ({pat.second[ph+NLEG], pat.second[ph]}),
      .first_win_i  (first_win),
      .second_win_i (second_win),
      .up_o         (gate_up_o[ph]),
      .lo_o         (gate_lo_o[ph])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= armed & ~pat.valid;
  end

  assign sector_err_o = err_q;

endmodule

// File: rtl/rgg_checker.sv
module rgg_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] tb_cnt_i,
  input logic [2:0]       gate_up_o,
  input logic [2:0]       gate_lo_o,
  input logic             sector_err_o
);

  logic prev_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_wrap <= 1'b0;
    else        prev_wrap <= (tb_cnt_i == '0);
  end

  assert_err_gates_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sector_err_o |-> (gate_up_o == 3'b000 && gate_lo_o == 3'b000));

  assert_two_or_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({gate_lo_o, gate_up_o}) == 2) || ($countones({gate_lo_o, gate_up_o}) == 0));

  assert_leg_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_up_o & gate_lo_o) == 3'b000);

  assert_err_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !prev_wrap |-> $stable(sector_err_o));

endmodule

bind rect_gate_gen rgg_checker #(.CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .tb_cnt_i     (tb_cnt_i),
  .gate_up_o    (gate_up_o),
  .gate_lo_o    (gate_lo_o),
  .sector_err_o (sector_err_o)
);

// File: tb/rect_gate_gen_tb_top.sv
module rect_gate_gen_tb_top;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       sector_i = '0;
  logic [CNT_W-1:0] duty_i = '0;
  logic [CNT_W-1:0] period_i = '0;
  logic [CNT_W-1:0] tb_cnt_i = 16'd7;
  logic [2:0]       gate_up_o;
  logic [2:0]       gate_lo_o;
  logic             sector_err_o;

  always #5 clk = ~clk;

  rect_gate_gen #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sector_i(sector_i), .duty_i(duty_i),
    .period_i(period_i), .tb_cnt_i(tb_cnt_i), .gate_up_o(gate_up_o),
    .gate_lo_o(gate_lo_o), .sector_err_o(sector_err_o)
  );

  typedef struct {
    logic [5:0] g;    // {lo c,b,a, up c,b,a}
    logic       err;
    int         tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;

  // bench model of the captured pattern
  bit               m_armed = 1'b0;
  logic [2:0]       m_sec = '0;
  logic [CNT_W-1:0] m_cmp = '0;

  function automatic string tag_name(input int t);
    case (t)
      1: return "R1";  2: return "R2";  4: return "R4";
      7: return "R7";  8: return "R8";  9: return "R9";
      default: return "R5";
    endcase
  endfunction

  // switch numbering here: upper a,b,c = 0,1,2 ; lower a,b,c = 3,4,5
  function automatic logic [5:0] model(input logic [2:0] s, input logic [CNT_W-1:0] c,
                                       input logic [CNT_W-1:0] cmp);
    int on_all, on_hi, on_lo;
    logic [5:0] r;
    case (s)
      3'd1: begin on_all = 0; on_hi = 4; on_lo = 5; end
      3'd2: begin on_all = 5; on_hi = 0; on_lo = 1; end
      3'd3: begin on_all = 1; on_hi = 3; on_lo = 5; end
      3'd4: begin on_all = 3; on_hi = 1; on_lo = 2; end
      3'd5: begin on_all = 2; on_hi = 4; on_lo = 3; end
      3'd6: begin on_all = 4; on_hi = 0; on_lo = 2; end
      default: return 6'b0;
    endcase
    r = '0;
    r[on_all] = 1'b1;
    if (c >= cmp) r[on_hi] = 1'b1; else r[on_lo] = 1'b1;
    return r;
  endfunction

  // driver: one count per cycle, pushes the result due one edge later (R3)
  task automatic drive(input logic [2:0] s, input logic [CNT_W-1:0] d,
                       input logic [CNT_W-1:0] p, input logic [CNT_W-1:0] c,
                       input int tag);
    exp_t e;
    @(negedge clk);
    sector_i = s; duty_i = d; period_i = p; tb_cnt_i = c;
    if (c == '0) begin
      m_armed = 1'b1;
      m_sec   = s;
      m_cmp   = (d > p) ? p : d;
    end
    e.err = m_armed && (m_sec == 3'd0 || m_sec == 3'd7);
    e.g   = m_armed ? model(m_sec, c, m_cmp) : 6'b0;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic run_period(input logic [2:0] s, input logic [CNT_W-1:0] d,
                            input logic [CNT_W-1:0] p, input int tag);
    for (int c = 0; c <= int'(p); c++) drive(s, d, p, c[CNT_W-1:0], tag);
  endtask

  // R2: inputs change in the second half of the period, outputs must not follow
  task automatic run_disturbed(input logic [2:0] s, input logic [CNT_W-1:0] d,
                               input logic [CNT_W-1:0] p, input logic [2:0] s2,
                               input logic [CNT_W-1:0] d2);
    for (int c = 0; c <= int'(p); c++) begin
      if (c > int'(p) / 2) drive(s2, d2, p + 16'd3, c[CNT_W-1:0], 2);
      else                 drive(s, d, p, c[CNT_W-1:0], 2);
    end
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #2;
    if (rst_n && exp_q.size() > 0) begin
      exp_t e;
      logic [5:0] act;
      e = exp_q.pop_front();
      act = {gate_lo_o, gate_up_o};
      n_tests++;
      if (act !== e.g || sector_err_o !== e.err) begin
        n_fail++;
        $display("FAIL %s/R3: gates=%b err=%b expected gates=%b err=%b",
                 tag_name(e.tag), act, sector_err_o, e.g, e.err);
      end
      if (!e.err && e.g != 6'b0) begin
        n_tests++;
        if ($countones(act) != 2 || (gate_up_o & gate_lo_o) != 3'b000) begin
          n_fail++;
          $display("FAIL R6: gates=%b expected two on, no shared leg (ref %b)", act, e.g);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    n_tests++;
    if (gate_up_o !== 3'b0 || gate_lo_o !== 3'b0 || sector_err_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: up=%b lo=%b err=%b expected 000 000 0", gate_up_o, gate_lo_o, sector_err_o);
    end
    rst_n = 1'b1;
    // R1: no zero count yet, gates remain off
    for (int c = 3; c < 7; c++) drive(3'd1, 16'd4, 16'd10, c[CNT_W-1:0], 1);
    // R4 / R5: every sector, mid compare
    for (int s = 1; s <= 6; s++) run_period(s[2:0], 16'd8, 16'd20, 4);
    run_period(3'd3, 16'd1, 16'd12, 5);
    run_period(3'd5, 16'd11, 16'd12, 5);
    // R2: mid-period disturbance
    run_disturbed(3'd2, 16'd6, 16'd14, 3'd5, 16'd1);
    run_disturbed(3'd4, 16'd9, 16'd14, 3'd0, 16'd2);
    // R7: invalid codes, then recovery
    run_period(3'd0, 16'd5, 16'd10, 7);
    run_period(3'd7, 16'd5, 16'd10, 7);
    run_period(3'd6, 16'd5, 16'd10, 7);
    // R8: duty above period saturates
    run_period(3'd1, 16'd40, 16'd10, 8);
    run_period(3'd4, 16'hFFFF, 16'd9, 8);
    // R9: zero duty
    run_period(3'd2, 16'd0, 16'd10, 9);
    run_period(3'd5, 16'd0, 16'd6, 9);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule